// File: doc/BRIEF.md
# Exception and Interrupt Vectoring Unit

This unit sits next to a 32-bit processor pipeline and turns event requests into a handler entry. Each cycle it looks at a non-maskable interrupt, a maskable interrupt with a 4-bit level, and a set of synchronous fault requests: address trap, illegal opcode, divide by zero, six floating-point conditions, and a trap instruction with a 5-bit parameter. It picks one winner and forms a 16-bit cause code. It loads the code into a 32-bit cause register and drives the handler address for one cycle. It also tells the pipeline whether to save the PC of the current instruction or the next one.

The unit keeps a flag that says a fault handler is running. The flag is set on fault entry and cleared by a return pulse. A fault that arrives while the flag is set is a nested fault. The new code is stacked into the upper half of the cause register, the first code stays in the lower half, and control goes to a shared recovery vector. When reset is released, the unit emits one entry for the boot vector and asks for no PC save.

Top module: `exc_vector_unit`

## Requirements
- R1: While `rst_n` is low, `vec_valid`=0, `ecr`=0x0000FFF0 and `in_handler`=0. On the first clock edge after release, the unit gives one entry with `vec_addr`=0xFFFFFFF0 and `save_pc_en`=0. Requests sampled on that edge are dropped.
- R2: Winner order is NMI, then maskable interrupt, then any synchronous fault. NMI gives code 0xFFD0 and address 0xFFFFFFD0. An interrupt entry clears `ecr[31:16]` and leaves `in_handler` unchanged.
- R3: A maskable interrupt at level n (0..15) gives code 0xFE00+16·n and address 0xFFFFFE00+16·n.
- R4: These faults save the current PC (`save_next_pc`=0). Address trap gives code 0xFFC0 and address 0xFFFFFFC0. Illegal opcode gives 0xFF90 and 0xFFFFFF90. Divide by zero gives 0xFF80 and 0xFFFFFF80.
- R5: A trap with parameter p (0..31) gives code 0xFFA0+p and address 0xFFFFFFA0+16·p[4]. It saves the next PC.
- R6: Every floating-point fault goes to 0xFFFFFF60 and saves the current PC. The codes are: invalid 0xFF70, zero-divide 0xFF68, overflow 0xFF64, reserved operand 0xFF60.
- R7: Among faults raised together, the order is address trap, illegal opcode, divide by zero, floating-point, trap. Within floating-point, the order is invalid, zero-divide, overflow, reserved operand.
- R8: A fault while `in_handler`=1 is nested and gives `ecr` = {new code, previous `ecr[15:0]`}. It goes to address 0xFFFFFFD0 and saves the current PC (`save_next_pc`=0).
- R9: An interrupt or NMI raised with `int_aborts`=1 saves the current PC. Otherwise it saves the next PC.
- R10: `fp_unf` and `fp_prec` have no effect. With no other request, `vec_valid` stays 0 and `ecr` keeps its value.
- R11: Any fault entry sets `in_handler`. A `reti` pulse with no fault in the same cycle clears it, while a fault in the same cycle keeps it set. A fault taken while `in_handler`=0 clears `ecr[31:16]`.
- R12: `vec_valid` is 1 in the cycle after each cycle that holds an accepted request, and 0 after a cycle with none. Every accepted event other than the boot entry sets `save_pc_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable interrupt request |
| int_req | input | 1 | Maskable interrupt request |
| int_level | input | 4 | Level of the maskable interrupt |
| int_aborts | input | 1 | Instruction in flight is abortable (divide, FP, bit-string) |
| exc_addr_trap | input | 1 | Address trap fault |
| exc_illegal_op | input | 1 | Illegal opcode fault |
| exc_div_zero | input | 1 | Integer divide by zero |
| fp_invalid | input | 1 | FP invalid operation |
| fp_zdiv | input | 1 | FP zero divide |
| fp_ovf | input | 1 | FP overflow |
| fp_unf | input | 1 | FP underflow (never raised, ignored) |
| fp_prec | input | 1 | FP precision loss (never raised, ignored) |
| fp_resop | input | 1 | FP reserved operand |
| trap_req | input | 1 | Trap instruction |
| trap_param | input | 5 | Trap parameter |
| reti | input | 1 | Return from fault handler |
| vec_valid | output | 1 | Handler entry strobe |
| vec_addr | output | 32 | Handler address |
| ecr | output | 32 | Cause register |
| save_next_pc | output | 1 | 1: save next PC, 0: save current PC |
| save_pc_en | output | 1 | The pipeline should save a PC for this entry |
| in_handler | output | 1 | Fault handler running |

## Verification
The assertions check, on every cycle, the rules that can be stated without knowing the exact code. Interrupts beat faults and clear the upper half of the cause register. Aborting interrupts save the current PC. A nested fault keeps the lower half of the cause register and uses the recovery vector. The return pulse clears the handler flag. The unused floating-point inputs raise no entry. The exact code and address for each event, the winner among faults raised together, and sequences of nested faults crossed with interrupts and returns are only shown by the bench. The bench sweeps every interrupt level, every trap parameter and every combination of floating-point and fault requests.

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter logic [15:0] VEC_HI = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_req,
  input  logic        int_req,
  input  logic [3:0]  int_level,
  input  logic        int_aborts,
  input  logic        exc_addr_trap,
  input  logic        exc_illegal_op,
  input  logic        exc_div_zero,
  input  logic        fp_invalid,
  input  logic        fp_zdiv,
  input  logic        fp_ovf,
  input  logic        fp_unf,
  input  logic        fp_prec,
  input  logic        fp_resop,
  input  logic        trap_req,
  input  logic [4:0]  trap_param,
  input  logic        reti,
  output logic        vec_valid,
  output logic [31:0] vec_addr,
  output logic [31:0] ecr,
  output logic        save_next_pc,
  output logic        save_pc_en,
  output logic        in_handler
);
  localparam logic [15:0] BOOT_CODE = 16'hFFF0;
  localparam logic [15:0] NMI_CODE  = 16'hFFD0;
  localparam logic [15:0] NEST_VEC  = 16'hFFD0;

  logic        boot_pend;
  logic [15:0] sync_code;
  logic [11:0] sync_vec;

  wire unused_fp = fp_unf | fp_prec;
  wire fp_any    = fp_invalid | fp_zdiv | fp_ovf | fp_resop;
  wire hard_any  = exc_addr_trap | exc_illegal_op | exc_div_zero | fp_any;
  wire sync_any  = hard_any | trap_req;
  wire irq_any   = nmi_req | int_req;
  wire [15:0] irq_code = nmi_req ? NMI_CODE : {8'hFE, int_level, 4'h0};

  always_comb begin
    sync_code = 16'h0000;
    sync_vec  = 12'h000;
    if (exc_addr_trap) begin
      sync_code = 16'hFFC0; sync_vec = 12'hFFC;
    end else if (exc_illegal_op) begin
      sync_code = 16'hFF90; sync_vec = 12'hFF9;
    end else if (exc_div_zero) begin
      sync_code = 16'hFF80; sync_vec = 12'hFF8;
    end else if (fp_any) begin
      sync_vec = 12'hFF6;
      if (fp_invalid)   sync_code = 16'hFF70;
      else if (fp_zdiv) sync_code = 16'hFF68;
      else if (fp_ovf)  sync_code = 16'hFF64;
      else              sync_code = 16'hFF60;
    end else if (trap_req) begin
      sync_code = {8'hFF, 3'b101, trap_param};
      sync_vec  = {8'hFF, 3'b101, trap_param[4]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_pend    <= 1'b1;
      vec_valid    <= 1'b0;
      vec_addr     <= 32'h0;
      ecr          <= {16'h0000, BOOT_CODE};
      save_next_pc <= 1'b0;
      save_pc_en   <= 1'b0;
      in_handler   <= 1'b0;
    end else if (boot_pend) begin
      boot_pend    <= 1'b0;
      vec_valid    <= 1'b1;
      vec_addr     <= {VEC_HI, BOOT_CODE};
      ecr          <= {16'h0000, BOOT_CODE};
      save_next_pc <= 1'b0;
      save_pc_en   <= 1'b0;
      in_handler   <= 1'b0;
    end else if (irq_any) begin
      vec_valid    <= 1'b1;
      vec_addr     <= {VEC_HI, irq_code[15:4], 4'h0};
      ecr          <= {16'h0000, irq_code};
      save_next_pc <= ~int_aborts;
      save_pc_en   <= 1'b1;
      in_handler   <= in_handler & ~reti;
    end else if (sync_any) begin
      vec_valid    <= 1'b1;
      save_pc_en   <= 1'b1;
      in_handler   <= 1'b1;
      if (in_handler) begin
        vec_addr     <= {VEC_HI, NEST_VEC};
        ecr          <= {sync_code, ecr[15:0]};
        save_next_pc <= 1'b0;
      end else begin
        vec_addr     <= {VEC_HI, sync_vec, 4'h0};
        ecr          <= {16'h0000, sync_code};
        save_next_pc <= ~hard_any;
      end
    end else begin
      vec_valid  <= 1'b0;
      in_handler <= in_handler & ~reti;
    end
  end
endmodule

module exc_vector_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        nmi_req,
  input logic        int_req,
  input logic        int_aborts,
  input logic        exc_addr_trap,
  input logic        exc_illegal_op,
  input logic        exc_div_zero,
  input logic        fp_invalid,
  input logic        fp_zdiv,
  input logic        fp_ovf,
  input logic        fp_unf,
  input logic        fp_prec,
  input logic        fp_resop,
  input logic        trap_req,
  input logic        reti,
  input logic        vec_valid,
  input logic [31:0] vec_addr,
  input logic [31:0] ecr,
  input logic        save_next_pc,
  input logic        save_pc_en,
  input logic        in_handler
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  wire irq_any = nmi_req | int_req;
  wire exc_any = exc_addr_trap | exc_illegal_op | exc_div_zero | fp_invalid
               | fp_zdiv | fp_ovf | fp_resop | trap_req;

  a_r1_boot_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> vec_valid && vec_addr == 32'hFFFFFFF0 && !save_pc_en);

  a_r2_irq_wins: assert property (@(posedge clk) disable iff (!rst_n)
    armed && irq_any |=> vec_valid && save_pc_en && ecr[31:16] == 16'h0000
                         && (ecr[15:8] == 8'hFE || ecr[15:0] == 16'hFFD0));

  a_r9_abort_current_pc: assert property (@(posedge clk) disable iff (!rst_n)
    armed && irq_any && int_aborts |=> !save_next_pc);

  a_r8_nested: assert property (@(posedge clk) disable iff (!rst_n)
    armed && in_handler && exc_any && !irq_any |=>
      vec_addr == 32'hFFFFFFD0 && !save_next_pc && ecr[15:0] == $past(ecr[15:0]));

  a_r11_enter_sets: assert property (@(posedge clk) disable iff (!rst_n)
    armed && exc_any && !irq_any |=> in_handler);

  a_r11_reti_clears: assert property (@(posedge clk) disable iff (!rst_n)
    armed && reti && !exc_any |=> !in_handler);

  a_r10_ignored_fp: assert property (@(posedge clk) disable iff (!rst_n)
    armed && (fp_unf || fp_prec) && !exc_any && !irq_any |=> !vec_valid && $stable(ecr));
endmodule

bind exc_vector_unit exc_vector_unit_chk u_chk (.*);

// File: tb/sim_exc_vector_unit.sv
module sim_exc_vector_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, nmi_req, int_req, int_aborts, exc_addr_trap, exc_illegal_op, exc_div_zero;
  logic fp_invalid, fp_zdiv, fp_ovf, fp_unf, fp_prec, fp_resop, trap_req, reti;
  logic [3:0]  int_level;
  logic [4:0]  trap_param;
  logic        vec_valid, save_next_pc, save_pc_en, in_handler;
  logic [31:0] vec_addr, ecr;

  exc_vector_unit u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] last_ecr;

  task automatic clr;
    nmi_req = 0; int_req = 0; int_level = 0; int_aborts = 0;
    exc_addr_trap = 0; exc_illegal_op = 0; exc_div_zero = 0;
    fp_invalid = 0; fp_zdiv = 0; fp_ovf = 0; fp_unf = 0; fp_prec = 0; fp_resop = 0;
    trap_req = 0; trap_param = 0; reti = 0;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(string tag, logic [31:0] a, logic [31:0] e, logic nx);
    step;
    clr;
    chk({tag, " valid"}, 32'(vec_valid), 32'd1);
    chk({tag, " addr"}, vec_addr, a);
    chk({tag, " ecr"}, ecr, e);
    chk({tag, " save_next"}, 32'(save_next_pc), 32'(nx));
    chk({tag, " save_en R12"}, 32'(save_pc_en), 32'd1);
    last_ecr = e;
  endtask

  task automatic do_reti;
    reti = 1;
    step;
    reti = 0;
    chk("R11 reti clears", 32'(in_handler), 32'd0);
    chk("R12 no entry", 32'(vec_valid), 32'd0);
  endtask

  function automatic logic [15:0] fp_code(logic inv, logic zd, logic ov);
    if (inv) return 16'hFF70;
    if (zd)  return 16'hFF68;
    if (ov)  return 16'hFF64;
    return 16'hFF60;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clr;
    rst_n = 0;
    repeat (3) step;
    chk("R1 reset valid", 32'(vec_valid), 32'd0);
    chk("R1 reset ecr", ecr, 32'h0000FFF0);
    chk("R1 reset flag", 32'(in_handler), 32'd0);
    rst_n = 1;
    exc_div_zero = 1;
    step;
    clr;
    chk("R1 boot valid", 32'(vec_valid), 32'd1);
    chk("R1 boot addr", vec_addr, 32'hFFFFFFF0);
    chk("R1 boot no save", 32'(save_pc_en), 32'd0);
    chk("R1 boot drops request", 32'(in_handler), 32'd0);
    step;
    chk("R12 strobe one cycle", 32'(vec_valid), 32'd0);

    for (int lvl = 0; lvl < 16; lvl++) begin
      for (int ab = 0; ab < 2; ab++) begin
        int_req = 1; int_level = 4'(lvl); int_aborts = ab[0];
        exc_div_zero = lvl[0];
        expect_ev("R2 R3 R9", 32'hFFFFFE00 + 32'(lvl * 16),
                  32'h0000FE00 + 32'(lvl * 16), !ab[0]);
        chk("R2 irq keeps flag", 32'(in_handler), 32'd0);
      end
    end

    for (int ab = 0; ab < 2; ab++) begin
      nmi_req = 1; int_req = 1; int_level = 4'd5; exc_addr_trap = 1; int_aborts = ab[0];
      expect_ev("R2 R9 nmi", 32'hFFFFFFD0, 32'h0000FFD0, !ab[0]);
    end

    for (int p = 0; p < 32; p++) begin
      trap_req = 1; trap_param = 5'(p);
      expect_ev("R5 trap", 32'hFFFFFFA0 + 32'((p / 16) * 16), 32'h0000FFA0 + 32'(p), 1'b1);
      chk("R11 entry sets flag", 32'(in_handler), 32'd1);
      do_reti;
    end

    exc_addr_trap = 1;  expect_ev("R4 addr trap", 32'hFFFFFFC0, 32'h0000FFC0, 1'b0); do_reti;
    exc_illegal_op = 1; expect_ev("R4 illegal", 32'hFFFFFF90, 32'h0000FF90, 1'b0); do_reti;
    exc_div_zero = 1;   expect_ev("R4 div zero", 32'hFFFFFF80, 32'h0000FF80, 1'b0); do_reti;

    for (int m = 1; m < 64; m++) begin
      fp_invalid = m[0]; fp_zdiv = m[1]; fp_ovf = m[2];
      fp_unf = m[3]; fp_prec = m[4]; fp_resop = m[5];
      if ((m & 6'b100111) == 0) begin
        step;
        clr;
        chk("R10 ignored no entry", 32'(vec_valid), 32'd0);
        chk("R10 ignored ecr", ecr, last_ecr);
      end else begin
        expect_ev("R6 R7 fp", 32'hFFFFFF60,
                  {16'h0000, fp_code(m[0], m[1], m[2])}, 1'b0);
        do_reti;
      end
    end

    for (int k = 1; k < 32; k++) begin
      logic [15:0] c;
      logic [31:0] a;
      exc_addr_trap = k[0]; exc_illegal_op = k[1]; exc_div_zero = k[2];
      fp_invalid = k[3]; trap_req = k[4]; trap_param = 5'h17;
      if (k[0])      begin c = 16'hFFC0; a = 32'hFFFFFFC0; end
      else if (k[1]) begin c = 16'hFF90; a = 32'hFFFFFF90; end
      else if (k[2]) begin c = 16'hFF80; a = 32'hFFFFFF80; end
      else if (k[3]) begin c = 16'hFF70; a = 32'hFFFFFF60; end
      else           begin c = 16'hFFB7; a = 32'hFFFFFFB0; end
      expect_ev("R7 priority", a, {16'h0000, c}, k == 16);
      do_reti;
    end

    exc_div_zero = 1;
    expect_ev("R11 first fault", 32'hFFFFFF80, 32'h0000FF80, 1'b0);
    exc_addr_trap = 1;
    expect_ev("R8 nested", 32'hFFFFFFD0, 32'hFFC0FF80, 1'b0);
    trap_req = 1; trap_param = 5'h03;
    expect_ev("R8 third keeps low", 32'hFFFFFFD0, 32'hFFA3FF80, 1'b0);
    reti = 1; fp_zdiv = 1;
    expect_ev("R8 R11 reti with fault", 32'hFFFFFFD0, 32'hFF68FF80, 1'b0);
    chk("R11 flag held", 32'(in_handler), 32'd1);
    int_req = 1; int_level = 4'd3;
    expect_ev("R2 irq in handler", 32'hFFFFFE30, 32'h0000FE30, 1'b1);
    chk("R2 flag unchanged", 32'(in_handler), 32'd1);
    fp_unf = 1; fp_prec = 1;
    step;
    clr;
    chk("R10 ignored in handler", ecr, last_ecr);
    do_reti;
    exc_illegal_op = 1;
    expect_ev("R11 single clears high", 32'hFFFFFF90, 32'h0000FF90, 1'b0);
    do_reti;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule